// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Flag

This block is the digital divider stage behind a clock-synthesis loop. One fast clock feeds it. That clock is either the oscillator output or a test clock when the loop is bypassed; the choice is made upstream, so this block sees a single clock. From that clock it derives three banks of divided clocks, a feedback clock with its own divider, and a coincidence flag. The flag marks the common rising edges of bank A and bank C, which is most useful when their frequencies stand in a non-binary ratio such as 3:2 or 4:3.

A 4-bit bank code picks one of sixteen divisor triples for banks A, B and C. A 3-bit code picks the feedback divisor. A steering input makes output D either carry the coincidence flag or act as one more copy of bank C. Every output has a 50% duty cycle and uses even divisors only, so the block needs no falling-edge logic. A synchronous master reset must follow any change of the codes. It puts every divider back to a common phase, so the first rising edge after release is shared by all outputs. Because a bypass test clock goes through the same dividers, several input edges may be needed before an output moves.

Top module: `clk_bank_divider`

## Requirements
- R1: While `rst` is sampled high on a rising edge of `clk`, all outputs (`qa`, `qb`, `qc`, `qd`, `qfb`, `sync`) are low after that edge.
- R2: On the first rising edge of `clk` after `rst` is sampled low, `qa`, `qb`, `qc` and `qfb` all go high together.
- R3: Divisors in fast-clock cycles for (A, B, C), by `fsel` value: 0:(2,2,2) 1:(4,4,4) 2:(2,4,4) 3:(4,8,8) 4:(2,6,6) 5:(4,6,6) 6:(2,8,8) 7:(6,8,8) 8:(6,8,24) 9:(6,8,12) 10:(4,4,8) 11:(2,2,6) 12:(4,4,6) 13:(6,6,8) 14:(8,8,8) 15:(6,6,6).
- R4: Every divided output with divisor d is high for d/2 fast cycles and then low for d/2, starting high on the first edge after reset release.
- R5: The feedback divisor is 2, 4, 6, 8, 12 or 16 for `fbsel` values 0 to 5, and 16 for values 6 and 7. It does not depend on `fsel`.
- R6: `sync` goes high at each edge where bank A and bank C both start a new period, and it stays high for exactly one bank-A period. It therefore recurs every lcm(divA, divC) cycles.
- R7: `sync` changes level only on an edge where `qa` rises.
- R8: When `sync_sel` is 0, `qd` equals `sync`. When `sync_sel` is 1, `qd` equals `qc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (oscillator or bypass test clock) |
| rst | input | 1 | Synchronous master reset, active high |
| fsel | input | 4 | Bank divisor code |
| fbsel | input | 3 | Feedback divisor code |
| sync_sel | input | 1 | Output D steering: 0 coincidence flag, 1 bank C copy |
| qa | output | 1 | Bank A clock |
| qb | output | 1 | Bank B clock |
| qc | output | 1 | Bank C clock |
| qd | output | 1 | Flag or bank C extension |
| qfb | output | 1 | Feedback clock |
| sync | output | 1 | Coincidence flag of banks A and C |

## Verification
The bench sweeps all 16 bank codes against all 8 feedback codes, which is 128 configurations. Each configuration starts from a reset and runs for 96 fast cycles, and every output is compared on every cycle with a level computed arithmetically from the cycle count. The equal-divisor codes separate a correct duty cycle from an off-by-one in the half period. The binary, 3:2 and 4:3 codes, together with the 24 and 12 cases, show whether the flag follows the least common multiple rather than just bank C. Feedback codes 6 and 7 check the clamp to 16. Alternating `sync_sel` between configurations exercises both sources of output D.

// File: rtl/clk_bank_divider.sv
module clk_bank_divider #(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] fsel,
  input  logic [2:0] fbsel,
  input  logic       sync_sel,
  output logic       qa,
  output logic       qb,
  output logic       qc,
  output logic       qd,
  output logic       qfb,
  output logic       sync
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] div_a, div_b, div_c, div_f;
  logic [CW-1:0] cnt_a, cnt_b, cnt_c, cnt_f;
  logic [CW-1:0] nxt_a, nxt_b, nxt_c, nxt_f;

  always_comb begin
    case (fsel)
      4'd0:  {div_a, div_b, div_c} = {CW'(2), CW'(2), CW'(2)};
      4'd1:  {div_a, div_b, div_c} = {CW'(4), CW'(4), CW'(4)};
      4'd2:  {div_a, div_b, div_c} = {CW'(2), CW'(4), CW'(4)};
      4'd3:  {div_a, div_b, div_c} = {CW'(4), CW'(8), CW'(8)};
      4'd4:  {div_a, div_b, div_c} = {CW'(2), CW'(6), CW'(6)};
      4'd5:  {div_a, div_b, div_c} = {CW'(4), CW'(6), CW'(6)};
      4'd6:  {div_a, div_b, div_c} = {CW'(2), CW'(8), CW'(8)};
      4'd7:  {div_a, div_b, div_c} = {CW'(6), CW'(8), CW'(8)};
      4'd8:  {div_a, div_b, div_c} = {CW'(6), CW'(8), CW'(24)};
      4'd9:  {div_a, div_b, div_c} = {CW'(6), CW'(8), CW'(12)};
      4'd10: {div_a, div_b, div_c} = {CW'(4), CW'(4), CW'(8)};
      4'd11: {div_a, div_b, div_c} = {CW'(2), CW'(2), CW'(6)};
      4'd12: {div_a, div_b, div_c} = {CW'(4), CW'(4), CW'(6)};
      4'd13: {div_a, div_b, div_c} = {CW'(6), CW'(6), CW'(8)};
      4'd14: {div_a, div_b, div_c} = {CW'(8), CW'(8), CW'(8)};
      default: {div_a, div_b, div_c} = {CW'(6), CW'(6), CW'(6)};
    endcase
  end

  always_comb begin
    case (fbsel)
      3'd0: div_f = CW'(2);
      3'd1: div_f = CW'(4);
      3'd2: div_f = CW'(6);
      3'd3: div_f = CW'(8);
      3'd4: div_f = CW'(12);
      default: div_f = CW'(16);
    endcase
  end

  assign nxt_a = (cnt_a >= div_a - ONE) ? '0 : cnt_a + ONE;
  assign nxt_b = (cnt_b >= div_b - ONE) ? '0 : cnt_b + ONE;
  assign nxt_c = (cnt_c >= div_c - ONE) ? '0 : cnt_c + ONE;
  assign nxt_f = (cnt_f >= div_f - ONE) ? '0 : cnt_f + ONE;

  function automatic logic first_half(input logic [CW-1:0] n, input logic [CW-1:0] d);
    return {n, 1'b0} < {1'b0, d};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a <= '1;
      cnt_b <= '1;
      cnt_c <= '1;
      cnt_f <= '1;
      qa    <= 1'b0;
      qb    <= 1'b0;
      qc    <= 1'b0;
      qfb   <= 1'b0;
      sync  <= 1'b0;
    end else begin
      cnt_a <= nxt_a;
      cnt_b <= nxt_b;
      cnt_c <= nxt_c;
      cnt_f <= nxt_f;
      qa    <= first_half(nxt_a, div_a);
      qb    <= first_half(nxt_b, div_b);
      qc    <= first_half(nxt_c, div_c);
      qfb   <= first_half(nxt_f, div_f);
      if (nxt_a == '0) sync <= (nxt_c == '0);
    end
  end

  assign qd = sync_sel ? qc : sync;

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!qa && !qb && !qc && !qd && !qfb && !sync));

  a_r2_aligned_start: assert property (@(posedge clk) disable iff (rst)
    ($past(rst, 2) && !$past(rst)) |-> (qa && qb && qc && qfb));

  a_r7_sync_on_qa_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(sync) |-> $rose(qa));

  a_r6_sync_with_qc: assert property (@(posedge clk) disable iff (rst)
    $rose(sync) |-> $rose(qc));

endmodule

// File: tb/tb_clk_bank_divider.sv
`timescale 1ns/1ps
module tb_clk_bank_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] fsel = '0;
  logic [2:0] fbsel = '0;
  logic sync_sel = 1'b0;
  logic qa, qb, qc, qd, qfb, sync;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_bank_divider dut (
    .clk(clk), .rst(rst), .fsel(fsel), .fbsel(fbsel), .sync_sel(sync_sel),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd), .qfb(qfb), .sync(sync)
  );

  function automatic int dva(input int f);
    int t[16] = '{2,4,2,4,2,4,2,6,6,6,4,2,4,6,8,6};
    return t[f];
  endfunction
  function automatic int dvb(input int f);
    int t[16] = '{2,4,4,8,6,6,8,8,8,8,4,2,4,6,8,6};
    return t[f];
  endfunction
  function automatic int dvc(input int f);
    int t[16] = '{2,4,4,8,6,6,8,8,24,12,8,6,6,8,8,6};
    return t[f];
  endfunction
  function automatic int dvf(input int s);
    int t[8] = '{2,4,6,8,12,16,16,16};
    return t[s];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input int f, input int s, input int n);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s fsel=%0d fbsel=%0d cycle=%0d actual=%0b expected=%0b", req, f, s, n, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        rst = 1'b1; fsel = 4'(f); fbsel = 3'(s); sync_sel = ((f + s) % 2 == 1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: all outputs low in reset
        chk("R1 qa", qa, 1'b0, f, s, 0);
        chk("R1 qb", qb, 1'b0, f, s, 0);
        chk("R1 qc", qc, 1'b0, f, s, 0);
        chk("R1 qd", qd, 1'b0, f, s, 0);
        chk("R1 qfb", qfb, 1'b0, f, s, 0);
        chk("R1 sync", sync, 1'b0, f, s, 0);
        rst = 1'b0;
        for (int n = 1; n <= 96; n++) begin
          int m, a, c, t0;
          logic es;
          @(posedge clk);
          @(negedge clk);
          m = n - 1; a = dva(f); c = dvc(f);
          t0 = (m / a) * a;
          es = ((t0 % c) == 0);
          if (n == 1) begin
            // R2: shared first rising edge
            chk("R2 qa", qa, 1'b1, f, s, n);
            chk("R2 qfb", qfb, 1'b1, f, s, n);
          end
          // R3 and R4: bank divisors and duty
          chk("R3_R4 qa", qa, (m % a) < a / 2, f, s, n);
          chk("R3_R4 qb", qb, (m % dvb(f)) < dvb(f) / 2, f, s, n);
          chk("R3_R4 qc", qc, (m % c) < c / 2, f, s, n);
          // R5: feedback divisor
          chk("R5 qfb", qfb, (m % dvf(s)) < dvf(s) / 2, f, s, n);
          // R6 and R7: coincidence flag over one A period
          chk("R6_R7 sync", sync, es, f, s, n);
          // R8: output D steering
          chk("R8 qd", qd, sync_sel ? ((m % c) < c / 2) : es, f, s, n);
          if (n == 48) begin
            sync_sel = ~sync_sel;
          end
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule